// File: doc/BRIEF.md
# Microstep Phase Current Sequencer

This block turns a step clock into the current reference for a two-phase bipolar stepper motor. Each rising edge on the step input moves an internal electrical angle forward or back by one step of the chosen excitation resolution. The block then reports, for each winding, a current magnitude in percent of full scale and a polarity bit. Phase A follows a cosine profile and phase B a sine profile, both taken from one shared quarter-wave table. The magnitudes are scaled by a selectable torque ratio. A downstream chopper and bridge stage turn these references into coil current.

The angle index has 32 positions per electrical cycle. The coarser resolutions move it by 8, 4 or 2 positions per step, and the finest moves it by 1. An active-low home input parks the sequence at its initial state and is the only time a new resolution is accepted. A home flag reports when the sequence sits at that initial state. An enable input blanks the reference outputs without stopping the angle index, so drive resumes from wherever the step count has reached.

Top module: `ustep_seq`

## Requirements
- R1: `mode_in` selects the resolution: 00 full step (index +/-8 per step), 01 half step (+/-4), 10 quarter step (+/-2), 11 eighth step (+/-1). For every mode except full step, the unscaled magnitudes are round(100*|cos|) for phase A and round(100*|sin|) for phase B at angle index*11.25 degrees. This gives 100,98,92,83,71,56,38,20,0 in eighth step; 100,92,71,38,0 in quarter step; 100,71,0 in half step. The index wraps modulo 32.
- R2: In full-step mode both phases carry an unscaled magnitude of 100, with polarities following the quadrant of an angle that starts at 45 degrees (index 4).
- R3: While `hold_n` is low, the index is held at its initial state. That state is index 0 (A=100, B=0) in the half, quarter and eighth modes, and index 4 (A=100, B=100, both positive) in full-step mode. `at_home` reads 1 in the initial state.
- R4: After `hold_n` returns high, the first rising step edge moves the sequence to the state that directly follows the initial state.
- R5: `dir_in`=0 steps forward (index increases, so B turns positive after leaving home). `dir_in`=1 steps in reverse (index decreases, so B turns negative).
- R6: While `en_in` is low, `drive_en` is 0 and both magnitudes and both polarity bits are 0. Step edges still advance the index, and outputs taken after `en_in` returns high reflect every step taken.
- R7: `torque_in` scales each magnitude to floor(m*r/100). The ratio r is 100 for 00, 75 for 01, 50 for 10 and 20 for 11.
- R8: A change of `mode_in` while `hold_n` is high has no effect on step size or magnitudes.
- R9: Each rising edge of `step_in` advances the index exactly once, however long `step_in` stays high. The outputs settle within SYNC_STAGES+2 clock cycles of the edge.
- R10: A polarity bit (`a_neg`, `b_neg`) is 1 only when that phase's reference is negative, and never while its magnitude is 0.
- R11: `at_home` is 1 whenever the index equals the initial state of the current mode, including after a full electrical cycle of steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Asynchronous step clock; rising edge advances |
| dir_in | input | 1 | 0 forward, 1 reverse |
| mode_in | input | 2 | Excitation resolution select |
| hold_n | input | 1 | Active-low hold at initial state |
| en_in | input | 1 | Active-high output enable |
| torque_in | input | 2 | Torque ratio select |
| a_mag | output | OUT_W | Phase A magnitude in percent |
| a_neg | output | 1 | Phase A negative polarity |
| b_mag | output | OUT_W | Phase B magnitude in percent |
| b_neg | output | 1 | Phase B negative polarity |
| at_home | output | 1 | Sequence is at its initial state |
| drive_en | output | 1 | Reference outputs are valid |

## Verification
A wrong angle index has no hidden place to sit. Within a few cycles of the step edge that caused it, it appears as a magnitude pair or a polarity pattern that disagrees with the expected sine and cosine. It also moves the home flag off its expected step. A lost or doubled step shifts every later sample of the sweep, and a misaligned index after a mode change shows table entries that the mode should never produce. Index motion while outputs are blanked becomes visible on the first sample after the enable returns.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int IDX_W    = 5;    // 32 angle positions per electrical cycle
    localparam int MAG_W    = 7;    // holds 0..100
    localparam int QUART    = 8;    // positions per quadrant
    localparam logic [MAG_W-1:0] FULL_PCT = MAG_W'(100);

    typedef enum logic [1:0] {
        EXC_FULL    = 2'b00,
        EXC_HALF    = 2'b01,
        EXC_QUARTER = 2'b10,
        EXC_EIGHTH  = 2'b11
    } exc_mode_e;

    typedef enum logic [1:0] {
        TQ_100 = 2'b00,
        TQ_75  = 2'b01,
        TQ_50  = 2'b10,
        TQ_20  = 2'b11
    } torque_e;

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             neg;
    } phase_ref_t;

    // cos(k * 11.25 deg) in percent for k = 0..8
    function automatic logic [MAG_W-1:0] qwave(input logic [3:0] k);
        case (k)
            4'd0:    return MAG_W'(100);
            4'd1:    return MAG_W'(98);
            4'd2:    return MAG_W'(92);
            4'd3:    return MAG_W'(83);
            4'd4:    return MAG_W'(71);
            4'd5:    return MAG_W'(56);
            4'd6:    return MAG_W'(38);
            4'd7:    return MAG_W'(20);
            default: return MAG_W'(0);
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] step_size(input exc_mode_e m);
        case (m)
            EXC_FULL:    return IDX_W'(8);
            EXC_HALF:    return IDX_W'(4);
            EXC_QUARTER: return IDX_W'(2);
            default:     return IDX_W'(1);
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] home_idx(input exc_mode_e m);
        return (m == EXC_FULL) ? IDX_W'(QUART / 2) : IDX_W'(0);
    endfunction

    function automatic logic [MAG_W-1:0] torque_pct(input torque_e t);
        case (t)
            TQ_100:  return MAG_W'(100);
            TQ_75:   return MAG_W'(75);
            TQ_50:   return MAG_W'(50);
            default: return MAG_W'(20);
        endcase
    endfunction

    function automatic logic [MAG_W-1:0] scale_pct(input logic [MAG_W-1:0] m,
                                                   input torque_e t);
        logic [2*MAG_W-1:0] prod;
        prod = m * torque_pct(t);
        return MAG_W'(prod / (2*MAG_W)'(100));
    endfunction

endpackage

// File: rtl/ustep_edge_sync.sv
module ustep_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    // STAGES synchroniser flops plus one edge-history flop
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], async_in};
        end
    end

    assign rise_pulse = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/ustep_index.sv
module ustep_index
    import ustep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_pulse,
    input  logic             dir,
    input  logic [1:0]       mode_in,
    input  logic             hold_n,
    output logic [IDX_W-1:0] pos_q,
    output exc_mode_e        mode_q
);
    exc_mode_e mode_sel;
    assign mode_sel = exc_mode_e'(mode_in);

    always_ff @(posedge clk) begin
        if (rst || !hold_n) begin
            mode_q <= mode_sel;
            pos_q  <= home_idx(mode_sel);
        end else if (step_pulse) begin
            if (dir) begin
                pos_q <= pos_q - step_size(mode_q);
            end else begin
                pos_q <= pos_q + step_size(mode_q);
            end
        end
    end

endmodule

// File: rtl/ustep_phase_lane.sv
module ustep_phase_lane
    import ustep_pkg::*;
#(
    parameter bit SINE = 1'b0
) (
    input  logic [IDX_W-1:0] pos,
    input  exc_mode_e        mode,
    input  torque_e          torque,
    output phase_ref_t       ph_o
);
    logic [1:0]       quad;
    logic [2:0]       off;
    logic             mirror;
    logic             neg_raw;
    logic [3:0]       k;
    logic [MAG_W-1:0] raw;

    always_comb begin
        quad = pos[IDX_W-1 -: 2];
        off  = pos[IDX_W-3:0];
        if (SINE) begin
            mirror  = ~quad[0];
            neg_raw = quad[1];
        end else begin
            mirror  = quad[0];
            neg_raw = quad[0] ^ quad[1];
        end
        k        = mirror ? (4'(QUART) - {1'b0, off}) : {1'b0, off};
        raw      = (mode == EXC_FULL) ? FULL_PCT : qwave(k);
        ph_o.mag = scale_pct(raw, torque);
        ph_o.neg = neg_raw & (raw != '0);
    end

endmodule

// File: rtl/ustep_phase_map.sv
module ustep_phase_map
    import ustep_pkg::*;
(
    input  logic [IDX_W-1:0] pos,
    input  exc_mode_e        mode,
    input  torque_e          torque,
    output phase_ref_t       ph_o [2]
);
    // lane 0 is phase A (cosine), lane 1 is phase B (sine)
    for (genvar g = 0; g < 2; g++) begin : g_lane
        ustep_phase_lane #(.SINE(g == 1)) lane_i (
            .pos    (pos),
            .mode   (mode),
            .torque (torque),
            .ph_o   (ph_o[g])
        );
    end

endmodule

// File: rtl/ustep_seq.sv
module ustep_seq
    import ustep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OUT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_in,
    input  logic             dir_in,
    input  logic [1:0]       mode_in,
    input  logic             hold_n,
    input  logic             en_in,
    input  logic [1:0]       torque_in,
    output logic [OUT_W-1:0] a_mag,
    output logic             a_neg,
    output logic [OUT_W-1:0] b_mag,
    output logic             b_neg,
    output logic             at_home,
    output logic             drive_en
);
    localparam int PAD_W = OUT_W - MAG_W;

    logic             step_pulse;
    logic [IDX_W-1:0] pos_q;
    exc_mode_e        mode_q;
    phase_ref_t       ph [2];

    ustep_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst        (rst),
        .async_in   (step_in),
        .rise_pulse (step_pulse)
    );

    ustep_index index_i (
        .clk        (clk),
        .rst        (rst),
        .step_pulse (step_pulse),
        .dir        (dir_in),
        .mode_in    (mode_in),
        .hold_n     (hold_n),
        .pos_q      (pos_q),
        .mode_q     (mode_q)
    );

    ustep_phase_map map_i (
        .pos    (pos_q),
        .mode   (mode_q),
        .torque (torque_e'(torque_in)),
        .ph_o   (ph)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_mag    <= '0;
            a_neg    <= 1'b0;
            b_mag    <= '0;
            b_neg    <= 1'b0;
            at_home  <= 1'b0;
            drive_en <= 1'b0;
        end else begin
            drive_en <= en_in;
            a_mag    <= en_in ? {{PAD_W{1'b0}}, ph[0].mag} : '0;
            a_neg    <= en_in & ph[0].neg;
            b_mag    <= en_in ? {{PAD_W{1'b0}}, ph[1].mag} : '0;
            b_neg    <= en_in & ph[1].neg;
            at_home  <= (pos_q == home_idx(mode_q));
        end
    end

endmodule

// File: rtl/ustep_seq_chk.sv
module ustep_seq_chk
    import ustep_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             hold_n,
    input logic             step_pulse,
    input logic [IDX_W-1:0] pos_q,
    input logic [OUT_W-1:0] a_mag,
    input logic             a_neg,
    input logic [OUT_W-1:0] b_mag,
    input logic             b_neg,
    input logic             at_home,
    input logic             drive_en
);
    p_home_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!hold_n && $past(!hold_n)) |=> at_home);

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (hold_n && !step_pulse) |=> $stable(pos_q));

    p_step_moves_r1: assert property (@(posedge clk) disable iff (rst)
        (hold_n && step_pulse) |=> !$stable(pos_q));

    p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (a_mag == '0 && b_mag == '0 && !a_neg && !b_neg));

    p_sign_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
        (a_neg |-> a_mag != '0) and (b_neg |-> b_mag != '0));

    p_mag_cap_r7: assert property (@(posedge clk) disable iff (rst)
        (a_mag <= OUT_W'(100)) && (b_mag <= OUT_W'(100)));

endmodule

bind ustep_seq ustep_seq_chk #(.OUT_W(OUT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .hold_n     (hold_n),
    .step_pulse (step_pulse),
    .pos_q      (pos_q),
    .a_mag      (a_mag),
    .a_neg      (a_neg),
    .b_mag      (b_mag),
    .b_neg      (b_neg),
    .at_home    (at_home),
    .drive_en   (drive_en)
);

// File: tb/ustep_seq_tb_top.sv
`timescale 1ns/1ps
module ustep_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_in = 1'b0;
    logic       dir_in = 1'b0;
    logic [1:0] mode_in = 2'b00;
    logic       hold_n = 1'b0;
    logic       en_in = 1'b1;
    logic [1:0] torque_in = 2'b00;
    logic [7:0] a_mag, b_mag;
    logic       a_neg, b_neg, at_home, drive_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    int mpos = 0;
    int mmode = 0;
    bit men = 1;

    always #2.5 clk = ~clk;

    ustep_seq dut_i (
        .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
        .mode_in(mode_in), .hold_n(hold_n), .en_in(en_in),
        .torque_in(torque_in), .a_mag(a_mag), .a_neg(a_neg),
        .b_mag(b_mag), .b_neg(b_neg), .at_home(at_home), .drive_en(drive_en)
    );

    function automatic int ratio(int t);
        case (t)
            0: return 100;
            1: return 75;
            2: return 50;
            default: return 20;
        endcase
    endfunction

    function automatic real wave(int p, bit sine);
        real ang;
        ang = p * 3.14159265358979 / 16.0;
        return sine ? $sin(ang) : $cos(ang);
    endfunction

    function automatic int exp_mag(int p, int m, bit sine, int t);
        real v;
        int r;
        v = wave(p, sine);
        if (v < 0.0) v = -v;
        r = $rtoi(v * 100.0 + 0.5);
        if (m == 0) r = 100;
        return (r * ratio(t)) / 100;
    endfunction

    function automatic bit exp_neg(int p, bit sine);
        return wave(p, sine) < -0.01;
    endfunction

    function automatic int home_of(int m);
        return (m == 0) ? 4 : 0;
    endfunction

    function automatic int stride(int m);
        return 8 >> m;
    endfunction

    task automatic check_val(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        int t = int'(torque_in);
        check_val({tag, " a_mag"},    int'(a_mag),  men ? exp_mag(mpos, mmode, 1'b0, t) : 0);
        check_val({tag, " a_neg"},    int'(a_neg),  men ? int'(exp_neg(mpos, 1'b0)) : 0);
        check_val({tag, " b_mag"},    int'(b_mag),  men ? exp_mag(mpos, mmode, 1'b1, t) : 0);
        check_val({tag, " b_neg"},    int'(b_neg),  men ? int'(exp_neg(mpos, 1'b1)) : 0);
        check_val({tag, " at_home"},  int'(at_home), int'(mpos == home_of(mmode)));
        check_val({tag, " drive_en"}, int'(drive_en), int'(men));
    endtask

    task automatic go_home(int m);
        @(negedge clk);
        hold_n  = 1'b0;
        mode_in = 2'(m);
        repeat (4) @(negedge clk);
        hold_n = 1'b1;
        repeat (2) @(negedge clk);
        mmode = m;
        mpos  = home_of(m);
    endtask

    task automatic do_step(int hi_cycles);
        @(negedge clk);
        step_in = 1'b1;
        repeat (hi_cycles) @(negedge clk);
        step_in = 1'b0;
        repeat (6) @(negedge clk);
        if (dir_in) mpos = (mpos - stride(mmode) + 32) % 32;
        else        mpos = (mpos + stride(mmode)) % 32;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        mmode = 0;
        mpos  = 4;
        // R3 R2: held at home in full-step mode after reset
        check_all("R3 R2 reset");
        hold_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R5 R7 R11 R10: full sweep of every mode, both directions
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                dir_in = 1'(d);
                go_home(m);
                check_all($sformatf("R3 home m%0d d%0d", m, d));
                for (int s = 0; s <= 32 / stride(m); s++) begin
                    torque_in = 2'(s % 4);
                    do_step(6);
                    check_all($sformatf("R1 R5 R7 R11 m%0d d%0d s%0d", m, d, s));
                end
            end
        end

        // R4: first step after release from home, half-step forward
        dir_in = 1'b0;
        torque_in = 2'b00;
        go_home(1);
        do_step(6);
        check_all("R4 first step");
        check_val("R4 a_mag 71", int'(a_mag), 71);
        check_val("R4 b_mag 71", int'(b_mag), 71);

        // R6: disabled outputs while steps continue
        go_home(3);
        @(negedge clk);
        en_in = 1'b0;
        men = 0;
        repeat (2) @(negedge clk);
        check_all("R6 disabled home");
        for (int i = 0; i < 3; i++) do_step(6);
        check_all("R6 disabled stepped");
        en_in = 1'b1;
        men = 1;
        repeat (2) @(negedge clk);
        check_all("R6 resume index 3");
        check_val("R6 a_mag idx3", int'(a_mag), 83);

        // R8: mode change ignored while running
        @(negedge clk);
        mode_in = 2'b00;
        do_step(6);
        check_all("R8 mode ignored");
        check_val("R8 a_mag idx4", int'(a_mag), 71);

        // R9: long step high gives a single advance
        do_step(40);
        check_all("R9 long high");
        repeat (20) @(negedge clk);
        check_all("R9 no extra step");

        // R3: hold while stepping keeps home
        @(negedge clk);
        hold_n = 1'b0;
        mode_in = 2'b10;
        mmode = 2;
        mpos = 0;
        step_in = 1'b1;
        repeat (8) @(negedge clk);
        step_in = 1'b0;
        repeat (8) @(negedge clk);
        check_all("R3 step during hold");
        hold_n = 1'b1;
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule